// File: doc/BRIEF.md
# Byte-Port DMA Channel Controller

This block is the programming face and address sequencer of a four-channel DMA controller in the style of the classic PC-compatible part. Software reaches it through a 4-bit I/O offset and an 8-bit data bus. Each channel has a 16-bit base address and a 16-bit base count. A single shared byte-pointer flip-flop decides whether the next access to one of these registers reaches the low byte or the high byte. Software loads the count with the transfer length minus one. It sets each channel's behaviour through a mode port and starts or stops a channel through a single-channel mask port.

Two page registers per channel supply address bits 23:16 and 31:24. They are loaded through a separate page port and never move the byte pointer. When a device acknowledges a transfer on an unmasked, non-cascade channel, the block presents the full bus address and then steps the channel's current address and count. On terminal count it pulses a flag. Depending on the mode, it then either masks the channel or reloads the channel from its base registers. A parameter selects word-channel operation, in which address and count are kept in 16-bit units.

Top module: `bytewide_dma_ctrl`

## Requirements
- R1: Any write to offset 0xC clears the byte pointer, so the next address or count access reaches the low byte.
- R2: Offsets 0x0 to 0x7 hold the address (even) and count (odd) registers of channels 0 to 3. Every read or write at these offsets toggles the byte pointer, low byte first. Writing 0x55 then 0xAA and reading twice returns 0x55 then 0xAA.
- R3: The count register holds length minus one. The `residue` output for the channel picked by `res_chan` is the stored current count plus one when WORD_MODE=0.
- R4: With WORD_MODE=1, `residue` is twice the stored count plus one. `xfer_addr` is {page_hi, page_lo[7:1], current address, 1'b0}.
- R5: A write to offset 0xA uses bits 1:0 to pick the channel. Bit 2 set masks the channel and bit 2 clear unmasks it. `chan_enable` shows the unmasked channels, and all channels are masked after reset.
- R6: A write to offset 0xB uses bits 1:0 to pick the channel. It stores the transfer type (bits 3:2, presented on `xfer_type` during an acknowledge), auto-initialise (bit 4), address decrement (bit 5) and mode select (bits 7:6, where 11 is cascade, shown on `chan_cascade`).
- R7: The page port (`pg_wr`, `pg_chan`, `pg_hi_sel`) loads the low or high page of a channel. It leaves the byte pointer unchanged. With WORD_MODE=0, `xfer_addr` is {page_hi, page_lo, current address}.
- R8: An acknowledge on an enabled, non-cascade channel moves the current address up by one, or down by one when decrement is set. It lowers the current count by one.
- R9: An acknowledge when the current count is 0 wraps the count to 0xFFFF, raises `tc_pulse` for that channel in the next cycle, and masks the channel unless auto-initialise is set.
- R10: With auto-initialise set, terminal count reloads the current address and count from the base registers, and the channel stays enabled.
- R11: A read of offset 0x8 returns the per-channel terminal-count flags in bits 3:0 and clears them.
- R12: A write to offset 0xD masks every channel, clears the byte pointer and clears the terminal-count flags.
- R13: An acknowledge on a masked channel or a cascade channel changes neither the address nor the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 4 | Register offset |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Read data, valid while io_rd is high |
| pg_wr | input | 1 | Page register write strobe |
| pg_chan | input | 2 | Page register channel |
| pg_hi_sel | input | 1 | 1 selects the high page, 0 the low page |
| pg_wdata | input | 8 | Page value |
| xfer_ack | input | 4 | Per-channel transfer acknowledge |
| xfer_addr | output | 32 | Bus address of the lowest acknowledged channel |
| xfer_type | output | 2 | Transfer type of the lowest acknowledged channel |
| tc_pulse | output | 4 | One-cycle terminal-count pulse per channel |
| chan_enable | output | 4 | Unmasked channels |
| chan_cascade | output | 4 | Channels in cascade mode |
| res_chan | input | 2 | Channel whose residue is shown |
| residue | output | 18 | Remaining transfer amount in bytes |

## Verification
Read data, `xfer_addr`, `xfer_type` and `residue` are combinational from the registers. The bench samples them one time step after raising the strobe, in the same cycle. The effect of a write, including the byte-pointer move, appears after the next rising edge, so readback starts in the following cycle. `tc_pulse` is registered and is sampled in the cycle after the acknowledging edge, while `chan_enable` and the stepped registers are checked from that same cycle onward. A byte-mode instance and a word-mode instance receive identical stimulus, so every sweep compares both against their own arithmetic expectations.

// File: rtl/bdma_pkg.sv
package bdma_pkg;
    localparam int NCH       = 4;
    localparam int CH_W      = $clog2(NCH);
    localparam int REG_W     = 16;
    localparam int BYTE_W    = 8;
    localparam int PORT_W    = 4;
    localparam int BUS_W     = 32;
    localparam int RES_W     = REG_W + 2;

    localparam logic [PORT_W-1:0] P_STAT  = 4'h8;
    localparam logic [PORT_W-1:0] P_MASK  = 4'hA;
    localparam logic [PORT_W-1:0] P_MODE  = 4'hB;
    localparam logic [PORT_W-1:0] P_CLRFF = 4'hC;
    localparam logic [PORT_W-1:0] P_MCLR  = 4'hD;

    localparam logic [1:0] MSEL_CASCADE = 2'b11;

    typedef struct packed {
        logic [1:0] msel;
        logic       decr;
        logic       autoinit;
        logic [1:0] ttype;
    } chmode_t;

    typedef struct packed {
        logic            reg_acc;
        logic            is_cnt;
        logic [CH_W-1:0] ch;
        logic            stat;
        logic            mask;
        logic            mode;
        logic            clrff;
        logic            mclr;
    } dec_t;

    function automatic chmode_t mode_from_byte(input logic [BYTE_W-1:0] b);
        chmode_t m;
        m.ttype    = b[3:2];
        m.autoinit = b[4];
        m.decr     = b[5];
        m.msel     = b[7:6];
        return m;
    endfunction

    function automatic logic [REG_W-1:0] put_byte(input logic [REG_W-1:0] old,
                                                  input logic hi,
                                                  input logic [BYTE_W-1:0] b);
        return hi ? {b, old[7:0]} : {old[15:8], b};
    endfunction

    function automatic logic [BYTE_W-1:0] get_byte(input logic [REG_W-1:0] v,
                                                   input logic hi);
        return hi ? v[15:8] : v[7:0];
    endfunction

    function automatic logic [RES_W-1:0] residue_of(input logic [REG_W-1:0] c,
                                                    input logic word);
        logic [RES_W-1:0] r;
        r = {2'b00, c} + RES_W'(1);
        return word ? (r << 1) : r;
    endfunction
endpackage

// File: rtl/bdma_port_decode.sv
module bdma_port_decode
    import bdma_pkg::*;
(
    input  logic [PORT_W-1:0] addr,
    output dec_t              dec
);
    always_comb begin
        dec         = '0;
        dec.reg_acc = (addr[3] == 1'b0);
        dec.is_cnt  = addr[0];
        dec.ch      = addr[CH_W:1];
        dec.stat    = (addr == P_STAT);
        dec.mask    = (addr == P_MASK);
        dec.mode    = (addr == P_MODE);
        dec.clrff   = (addr == P_CLRFF);
        dec.mclr    = (addr == P_MCLR);
    end
endmodule

// File: rtl/bdma_channel.sv
module bdma_channel
    import bdma_pkg::*;
#(
    parameter bit WORD_MODE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic              byte_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              mode_we,
    input  chmode_t           mode_in,
    input  logic              mask_we,
    input  logic              mask_set,
    input  logic              mclr,
    input  logic              pg_lo_we,
    input  logic              pg_hi_we,
    input  logic [BYTE_W-1:0] pg_data,
    input  logic              ack,
    output logic [REG_W-1:0]  cur_addr,
    output logic [REG_W-1:0]  cur_cnt,
    output chmode_t           mode_q,
    output logic              masked,
    output logic              tc_evt,
    output logic [BUS_W-1:0]  bus_addr
);
    logic [REG_W-1:0]  base_addr;
    logic [REG_W-1:0]  base_cnt;
    logic [BYTE_W-1:0] page_lo;
    logic [BYTE_W-1:0] page_hi;
    logic              step;
    logic              at_tc;

    assign step  = ack && !masked && (mode_q.msel != MSEL_CASCADE);
    assign at_tc = step && (cur_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
            page_lo   <= '0;
            page_hi   <= '0;
            mode_q    <= '0;
            masked    <= 1'b1;
            tc_evt    <= 1'b0;
        end else begin
            tc_evt <= at_tc;
            if (step) begin
                if (at_tc && mode_q.autoinit) begin
                    cur_addr <= base_addr;
                    cur_cnt  <= base_cnt;
                end else begin
                    cur_addr <= mode_q.decr ? cur_addr - 1'b1 : cur_addr + 1'b1;
                    cur_cnt  <= cur_cnt - 1'b1;
                end
            end
            if (wr_addr) begin
                base_addr <= put_byte(base_addr, byte_hi, wdata);
                cur_addr  <= put_byte(cur_addr, byte_hi, wdata);
            end
            if (wr_cnt) begin
                base_cnt <= put_byte(base_cnt, byte_hi, wdata);
                cur_cnt  <= put_byte(cur_cnt, byte_hi, wdata);
            end
            if (pg_lo_we) page_lo <= pg_data;
            if (pg_hi_we) page_hi <= pg_data;
            if (mode_we)  mode_q  <= mode_in;
            if (mask_we)  masked  <= mask_set;
            if (mclr)     masked  <= 1'b1;
            if (at_tc && !mode_q.autoinit) masked <= 1'b1;
        end
    end

    generate
        if (WORD_MODE) begin : g_word
            assign bus_addr = {page_hi, page_lo[7:1], cur_addr, 1'b0};
        end else begin : g_byte
            assign bus_addr = {page_hi, page_lo, cur_addr};
        end
    endgenerate
endmodule

// File: rtl/bytewide_dma_ctrl.sv
module bytewide_dma_ctrl
    import bdma_pkg::*;
#(
    parameter bit WORD_MODE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [7:0]        io_rdata,
    input  logic              pg_wr,
    input  logic [1:0]        pg_chan,
    input  logic              pg_hi_sel,
    input  logic [7:0]        pg_wdata,
    input  logic [3:0]        xfer_ack,
    output logic [31:0]       xfer_addr,
    output logic [1:0]        xfer_type,
    output logic [3:0]        tc_pulse,
    output logic [3:0]        chan_enable,
    output logic [3:0]        chan_cascade,
    input  logic [1:0]        res_chan,
    output logic [17:0]       residue
);
    dec_t             dec;
    logic             ff_hi;
    logic             reg_access;
    logic [NCH-1:0]   tc_flags;
    logic [NCH-1:0]   masked_v;
    logic [NCH-1:0]   autoinit_v;
    logic [NCH-1:0]   cnt_zero;
    logic [REG_W-1:0] addr_a [NCH];
    logic [REG_W-1:0] cnt_a  [NCH];
    chmode_t          mode_a [NCH];
    logic [BUS_W-1:0] bus_a  [NCH];
    logic [2:0]       wdata_unused;

    assign wdata_unused = io_wdata[7:5];

    bdma_port_decode u_dec (.addr(io_addr), .dec(dec));

    assign reg_access = dec.reg_acc && (io_wr || io_rd);

    always_ff @(posedge clk) begin
        if (rst) begin
            ff_hi <= 1'b0;
        end else if (io_wr && (dec.clrff || dec.mclr)) begin
            ff_hi <= 1'b0;
        end else if (reg_access) begin
            ff_hi <= ~ff_hi;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tc_flags <= '0;
        end else if (io_wr && dec.mclr) begin
            tc_flags <= '0;
        end else begin
            tc_flags <= ((io_rd && dec.stat) ? '0 : tc_flags) | tc_pulse;
        end
    end

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            logic sel_reg;
            assign sel_reg = io_wr && dec.reg_acc && (dec.ch == CH_W'(i));

            bdma_channel #(.WORD_MODE(WORD_MODE)) u_ch (
                .clk      (clk),
                .rst      (rst),
                .wr_addr  (sel_reg && !dec.is_cnt),
                .wr_cnt   (sel_reg && dec.is_cnt),
                .byte_hi  (ff_hi),
                .wdata    (io_wdata),
                .mode_we  (io_wr && dec.mode && (io_wdata[1:0] == CH_W'(i))),
                .mode_in  (mode_from_byte(io_wdata)),
                .mask_we  (io_wr && dec.mask && (io_wdata[1:0] == CH_W'(i))),
                .mask_set (io_wdata[2]),
                .mclr     (io_wr && dec.mclr),
                .pg_lo_we (pg_wr && !pg_hi_sel && (pg_chan == CH_W'(i))),
                .pg_hi_we (pg_wr && pg_hi_sel && (pg_chan == CH_W'(i))),
                .pg_data  (pg_wdata),
                .ack      (xfer_ack[i]),
                .cur_addr (addr_a[i]),
                .cur_cnt  (cnt_a[i]),
                .mode_q   (mode_a[i]),
                .masked   (masked_v[i]),
                .tc_evt   (tc_pulse[i]),
                .bus_addr (bus_a[i])
            );

            assign chan_enable[i]  = ~masked_v[i];
            assign chan_cascade[i] = (mode_a[i].msel == MSEL_CASCADE);
            assign autoinit_v[i]   = mode_a[i].autoinit;
            assign cnt_zero[i]     = (cnt_a[i] == '0);
        end
    endgenerate

    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            if (dec.reg_acc) begin
                io_rdata = get_byte(dec.is_cnt ? cnt_a[dec.ch] : addr_a[dec.ch], ff_hi);
            end else if (dec.stat) begin
                io_rdata = {{(BYTE_W-NCH){1'b0}}, tc_flags};
            end
        end
    end

    always_comb begin
        xfer_addr = '0;
        xfer_type = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (xfer_ack[i]) begin
                xfer_addr = bus_a[i];
                xfer_type = mode_a[i].ttype;
            end
        end
    end

    assign residue = residue_of(cnt_a[res_chan], WORD_MODE);
endmodule

// File: rtl/bdma_checker.sv
module bdma_checker (
    input logic       clk,
    input logic       rst,
    input logic [3:0] io_addr,
    input logic       io_wr,
    input logic       io_rd,
    input logic       ff_hi,
    input logic [3:0] xfer_ack,
    input logic [3:0] tc_pulse,
    input logic [3:0] chan_enable,
    input logic [3:0] chan_cascade,
    input logic [3:0] autoinit_v,
    input logic [3:0] cnt_zero
);
    p_clrff_r1: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == 4'hC) |=> !ff_hi);

    p_toggle_r2: assert property (@(posedge clk) disable iff (rst)
        ((io_wr || io_rd) && !io_addr[3]) |=> (ff_hi != $past(ff_hi)));

    p_mclr_r12: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == 4'hD) |=> (chan_enable == 4'b0000 && !ff_hi));

    generate
        for (genvar i = 0; i < 4; i++) begin : g_chk
            p_tc_mask_r9: assert property (@(posedge clk) disable iff (rst)
                (xfer_ack[i] && chan_enable[i] && !chan_cascade[i] && cnt_zero[i]
                 && !autoinit_v[i]) |=> (tc_pulse[i] && !chan_enable[i]));

            p_tc_auto_r10: assert property (@(posedge clk) disable iff (rst)
                (xfer_ack[i] && chan_enable[i] && !chan_cascade[i] && cnt_zero[i]
                 && autoinit_v[i] && !io_wr) |=> (tc_pulse[i] && chan_enable[i]));

            p_idle_no_tc_r13: assert property (@(posedge clk) disable iff (rst)
                (xfer_ack[i] && (!chan_enable[i] || chan_cascade[i])) |=> !tc_pulse[i]);
        end
    endgenerate
endmodule

bind bytewide_dma_ctrl bdma_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .io_addr      (io_addr),
    .io_wr        (io_wr),
    .io_rd        (io_rd),
    .ff_hi        (ff_hi),
    .xfer_ack     (xfer_ack),
    .tc_pulse     (tc_pulse),
    .chan_enable  (chan_enable),
    .chan_cascade (chan_cascade),
    .autoinit_v   (autoinit_v),
    .cnt_zero     (cnt_zero)
);

// File: tb/bytewide_dma_ctrl_tb_top.sv
module bytewide_dma_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic        pg_wr = 1'b0, pg_hi_sel = 1'b0;
    logic [1:0]  pg_chan = '0, res_chan = '0;
    logic [7:0]  pg_wdata = '0;
    logic [3:0]  xfer_ack = '0;

    logic [7:0]  rd_b, rd_w;
    logic [31:0] xa_b, xa_w;
    logic [1:0]  xt_b, xt_w;
    logic [3:0]  tc_b, tc_w, en_b, en_w, cas_b, cas_w;
    logic [17:0] res_b, res_w;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bytewide_dma_ctrl #(.WORD_MODE(1'b0)) dut_i (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr),
        .io_rd(io_rd), .io_rdata(rd_b), .pg_wr(pg_wr), .pg_chan(pg_chan),
        .pg_hi_sel(pg_hi_sel), .pg_wdata(pg_wdata), .xfer_ack(xfer_ack),
        .xfer_addr(xa_b), .xfer_type(xt_b), .tc_pulse(tc_b), .chan_enable(en_b),
        .chan_cascade(cas_b), .res_chan(res_chan), .residue(res_b));

    bytewide_dma_ctrl #(.WORD_MODE(1'b1)) dut_w (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr),
        .io_rd(io_rd), .io_rdata(rd_w), .pg_wr(pg_wr), .pg_chan(pg_chan),
        .pg_hi_sel(pg_hi_sel), .pg_wdata(pg_wdata), .xfer_ack(xfer_ack),
        .xfer_addr(xa_w), .xfer_type(xt_w), .tc_pulse(tc_w), .chan_enable(en_w),
        .chan_cascade(cas_w), .res_chan(res_chan), .residue(res_w));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic io_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [3:0] a, output logic [7:0] db, output logic [7:0] dw);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        db = rd_b; dw = rd_w;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic rd16(input logic [3:0] a, output logic [15:0] vb, output logic [15:0] vw);
        logic [7:0] lb, lw, hb, hw;
        io_write(4'hC, 8'h00);
        io_read(a, lb, lw);
        io_read(a, hb, hw);
        vb = {hb, lb}; vw = {hw, lw};
    endtask

    task automatic wr16(input logic [3:0] a, input logic [15:0] v);
        io_write(4'hC, 8'h00);
        io_write(a, v[7:0]);
        io_write(a, v[15:8]);
    endtask

    task automatic set_page(input logic [1:0] ch, input logic hi, input logic [7:0] v);
        @(negedge clk);
        pg_chan = ch; pg_hi_sel = hi; pg_wdata = v; pg_wr = 1'b1;
        @(negedge clk);
        pg_wr = 1'b0;
    endtask

    task automatic ack(input logic [1:0] ch, output logic [31:0] ab, output logic [31:0] aw,
                       output logic [3:0] tb, output logic [3:0] tw);
        @(negedge clk);
        xfer_ack = 4'b0001 << ch;
        #1;
        ab = xa_b; aw = xa_w;
        @(negedge clk);
        xfer_ack = '0;
        #1;
        tb = tc_b; tw = tc_w;
    endtask

    function automatic logic [7:0] mode_byte(input logic [1:0] ch, input logic [1:0] tt,
                                             input logic ai, input logic dn, input logic [1:0] ms);
        return {ms, dn, ai, tt, ch};
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b, w, b2, w2;
        logic [15:0] vb, vw;
        logic [31:0] ab, aw;
        logic [3:0]  tb, tw;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R5 reset state: all masked; R3/R4 residue of zero count
        chk("R5 reset enable byte", {28'b0, en_b}, 32'h0);
        chk("R5 reset enable word", {28'b0, en_w}, 32'h0);
        chk("R3 reset residue", {14'b0, res_b}, 32'd1);
        chk("R4 reset residue word", {14'b0, res_w}, 32'd2);
        io_read(4'h8, b, w);
        chk("R11 reset status", {24'b0, b}, 32'h0);

        // R2 / R3 / R4 sweep over channels and both register kinds
        for (int ch = 0; ch < 4; ch++) begin
            io_write(4'hC, 8'h00);
            io_write(4'(2*ch), 8'h55);
            io_write(4'(2*ch), 8'hAA);
            io_write(4'hC, 8'h00);
            io_read(4'(2*ch), b, w);
            chk("R2 addr low readback", {24'b0, b}, 32'h55);
            io_read(4'(2*ch), b2, w2);
            chk("R2 addr high readback", {24'b0, b2}, 32'hAA);
            chk("R2 addr word dut", {16'b0, w2, w}, 32'hAA55);
            for (int k = 0; k < 3; k++) begin
                int len;
                len = 1 + ch * 300 + k * 4099;
                wr16(4'(2*ch+1), 16'(len - 1));
                rd16(4'(2*ch+1), vb, vw);
                chk("R3 count readback", {16'b0, vb}, 32'(len - 1));
                res_chan = 2'(ch);
                #1;
                chk("R3 residue", {14'b0, res_b}, 32'(len));
                chk("R4 residue doubled", {14'b0, res_w}, 32'(2 * len));
            end
        end

        // R1 clearing the pointer mid-pair redirects to low byte
        io_write(4'hC, 8'h00);
        io_write(4'h2, 8'h11);
        io_write(4'hC, 8'h5A);
        io_write(4'h2, 8'h22);
        io_write(4'h2, 8'h33);
        rd16(4'h2, vb, vw);
        chk("R1 clear pointer", {16'b0, vb}, 32'h3322);

        // R7 page writes leave the pointer alone
        io_write(4'hC, 8'h00);
        io_write(4'h0, 8'h34);
        set_page(2'd0, 1'b0, 8'h56);
        set_page(2'd0, 1'b1, 8'h78);
        io_write(4'h0, 8'h12);
        rd16(4'h0, vb, vw);
        chk("R7 pointer kept across page", {16'b0, vb}, 32'h1234);

        // R6/R8 channel 0 increment, write type
        wr16(4'h1, 16'd9);
        io_write(4'hB, mode_byte(2'd0, 2'b01, 1'b0, 1'b0, 2'b01));
        io_write(4'hA, 8'h00);
        chk("R5 unmask ch0", {28'b0, en_b}, 32'h1);
        for (int s = 0; s < 3; s++) begin
            ack(2'd0, ab, aw, tb, tw);
            chk("R7 bus address", ab, {8'h78, 8'h56, 16'(16'h1234 + s)});
            chk("R4 word bus address", aw, {8'h78, 7'h2B, 16'(16'h1234 + s), 1'b0});
        end
        @(negedge clk);
        xfer_ack = 4'b0001;
        #1;
        chk("R6 transfer type", {30'b0, xt_b}, 32'h1);
        @(negedge clk);
        xfer_ack = '0;
        rd16(4'h0, vb, vw);
        chk("R8 address increments", {16'b0, vb}, 32'h1238);
        rd16(4'h1, vb, vw);
        chk("R8 count decrements", {16'b0, vb}, 32'd5);

        // R8 decrement on channel 1, read type
        wr16(4'h2, 16'h0100);
        wr16(4'h3, 16'd20);
        io_write(4'hB, mode_byte(2'd1, 2'b10, 1'b0, 1'b1, 2'b01));
        io_write(4'hA, 8'h01);
        ack(2'd1, ab, aw, tb, tw);
        ack(2'd1, ab, aw, tb, tw);
        rd16(4'h2, vb, vw);
        chk("R8 address decrements", {16'b0, vb}, 32'h00FE);

        // R9 terminal count on channel 2, R11 status
        wr16(4'h4, 16'h0040);
        wr16(4'h5, 16'd1);
        io_write(4'hB, mode_byte(2'd2, 2'b01, 1'b0, 1'b0, 2'b01));
        io_write(4'hA, 8'h02);
        ack(2'd2, ab, aw, tb, tw);
        chk("R9 no tc early", {28'b0, tb}, 32'h0);
        ack(2'd2, ab, aw, tb, tw);
        chk("R9 tc pulse", {28'b0, tb}, 32'h4);
        chk("R9 channel masked", {28'b0, en_b & 4'h4}, 32'h0);
        @(negedge clk);
        chk("R9 pulse one cycle", {28'b0, tc_b}, 32'h0);
        rd16(4'h5, vb, vw);
        chk("R9 count wraps", {16'b0, vb}, 32'hFFFF);
        io_read(4'h8, b, w);
        chk("R11 status flags", {24'b0, b}, 32'h4);
        io_read(4'h8, b, w);
        chk("R11 status cleared", {24'b0, b}, 32'h0);

        // R13 ack on masked channel 2
        ack(2'd2, ab, aw, tb, tw);
        rd16(4'h4, vb, vw);
        chk("R13 masked no step", {16'b0, vb}, 32'h0042);

        // R10 autoinit on channel 3
        wr16(4'h6, 16'h1000);
        wr16(4'h7, 16'd0);
        io_write(4'hB, mode_byte(2'd3, 2'b01, 1'b1, 1'b0, 2'b01));
        io_write(4'hA, 8'h03);
        ack(2'd3, ab, aw, tb, tw);
        chk("R10 tc pulse", {28'b0, tb}, 32'h8);
        chk("R10 stays enabled", {28'b0, en_b & 4'h8}, 32'h8);
        rd16(4'h6, vb, vw);
        chk("R10 address reload", {16'b0, vb}, 32'h1000);
        rd16(4'h7, vb, vw);
        chk("R10 count reload", {16'b0, vb}, 32'h0);

        // R13/R6 cascade channel 1 ignores acks
        io_write(4'hB, mode_byte(2'd1, 2'b00, 1'b0, 1'b0, 2'b11));
        chk("R6 cascade flag", {28'b0, cas_b}, 32'h2);
        ack(2'd1, ab, aw, tb, tw);
        rd16(4'h2, vb, vw);
        chk("R13 cascade no step", {16'b0, vb}, 32'h00FE);

        // R5 mask bit sets mask
        io_write(4'hA, 8'h04);
        chk("R5 mask ch0", {28'b0, en_b & 4'h1}, 32'h0);

        // R12 master clear
        io_write(4'hA, 8'h02);
        io_read(4'h6, b, w);
        io_write(4'hD, 8'h00);
        chk("R12 all masked", {28'b0, en_b}, 32'h0);
        chk("R12 all masked word", {28'b0, en_w}, 32'h0);
        io_read(4'h6, b, w);
        chk("R12 pointer cleared", {24'b0, b}, 32'h00);
        io_read(4'h6, b, w);
        chk("R12 then high byte", {24'b0, b}, 32'h10);
        io_read(4'h8, b, w);
        chk("R12 flags cleared", {24'b0, b}, 32'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule